// File: doc/BRIEF.md
# Serial-RGB panel sync and pixel-serialising timing generator

This block produces the line and frame timing for a 240x320 RGB panel. It can drive the panel in two ways. In the narrow mode, each pixel goes over a 6-bit bus as three back-to-back transfers. In the wide mode, each pixel goes over the full 18-bit bus in one transfer. The block outputs active-low horizontal and vertical sync, a data-enable, a transfer-phase index, a line-start pulse and a frame-start pulse. It also requests one 18-bit pixel from an upstream source for each active pixel slot.

All timing advances on a single DOTCLK enable (`dot_en`), and every output is a register that changes only on an enabled edge. In narrow mode a line is 760 transfers long: 10 of sync, 20 of back porch, 720 active and 10 of front porch. In wide mode the active part shrinks to 240, so a line is 280 transfers long. A frame is 328 lines in both modes: 2 of sync, 2 of back porch, 320 active lines and 4 of front porch. The mode input is taken only at a frame boundary, so a frame never mixes the two modes.

Top module: `lcd_sync_gen`

## Requirements
- R1: A line lasts H_SYNC+H_BACK+K*H_PIX+H_FRONT enabled ticks, where K=3 in narrow mode and K=1 in wide mode. `hsync_n` is low for the first H_SYNC ticks of each line. `line_start` is high for exactly the first tick of each line.
- R2: A frame lasts V_SYNC+V_BACK+V_LINES+V_FRONT lines. `vsync_n` is low for the first V_SYNC whole lines and falls on the same tick as `hsync_n`. `frame_start` is high only on the first tick of a frame.
- R3: `de` is high only on active transfer slots of active lines. Line positions H_SYNC+H_BACK up to that value plus K*H_PIX-1 are active. `bus_data` is all zero whenever `de` is low.
- R4: In narrow mode (`wide_mode`=0), the three slots of a pixel carry `phase` 0, 1 and 2. On those slots `bus_data[5:0]` carries red = pixel[17:12], then green = pixel[11:6], then blue = pixel[5:0], and `bus_data[17:6]` is zero.
- R5: In wide mode (`wide_mode`=1), each active slot carries the whole 18-bit pixel on `bus_data` with `phase`=0.
- R6: `pix_req` is high for exactly the one tick that comes before each pixel's first slot. The value of `pix_data` at the end of that tick is the pixel that is sent.
- R7: `wide_mode` is sampled only on the enabled edge that begins the last tick of a frame, and during reset. A change at any other time has no effect until the next frame.
- R8: No output changes on a clock edge where `dot_en` is low.
- R9: During reset and until the first enabled edge after it, `hsync_n`=1, `vsync_n`=1, and all other outputs are 0. The first enabled edge begins a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dot_en | input | 1 | DOTCLK tick enable |
| wide_mode | input | 1 | 0 = three 6-bit transfers per pixel, 1 = one 18-bit transfer |
| pix_data | input | 18 | Pixel from the source, {red, green, blue} |
| pix_req | output | 1 | Pixel request, one tick ahead of the red slot |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable |
| phase | output | 2 | Transfer index within the pixel |
| bus_data | output | 18 | Panel data bus |
| line_start | output | 1 | First tick of a line |
| frame_start | output | 1 | First tick of a frame |

## Verification
If the horizontal counter is corrupted, `line_start` and `hsync_n` slip at the very next wrap, and `de` opens on the wrong slot within one line. If the phase counter is wrong, colours rotate on the bus at the first active pixel. A request issued on the wrong tick makes the wrong word appear as red on the next tick. If the mode register is wrong, the line length changes, and the following `line_start` lands at 280 instead of 760 transfers (or the reverse). The bench compares every output on every clock with a position model, so each of these faults appears within one line of when it occurs.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;
  // Decoded properties of one screen position.
  typedef struct packed {
    logic       hsync;
    logic       vsync;
    logic       act;
    logic [1:0] ph;
    logic       red;
    logic       line0;
    logic       frame0;
  } slot_t;
endpackage

// File: rtl/lcd_hv_counter.sv
module lcd_hv_counter #(
  parameter int H_SYNC  = 10,
  parameter int H_BACK  = 20,
  parameter int H_PIX   = 240,
  parameter int H_FRONT = 10,
  parameter int V_TOTAL = 328,
  parameter int HW      = 10,
  parameter int VW      = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dot_en,
  input  logic          wide_in,
  output logic [HW-1:0] h,
  output logic [VW-1:0] v,
  output logic [1:0]    ph,
  output logic [HW-1:0] h_nxt,
  output logic [VW-1:0] v_nxt,
  output logic [1:0]    ph_nxt,
  output logic          wide_q
);
  localparam logic [HW-1:0] LAST_N = HW'(H_SYNC + H_BACK + 3*H_PIX + H_FRONT - 1);
  localparam logic [HW-1:0] LAST_W = HW'(H_SYNC + H_BACK + H_PIX + H_FRONT - 1);
  localparam logic [HW-1:0] ACT0   = HW'(H_SYNC + H_BACK);
  localparam logic [VW-1:0] VLAST  = VW'(V_TOTAL - 1);

  logic [1:0] ph_max;

  always_comb begin
    ph_max = wide_q ? 2'd0 : 2'd2;
    if (h == (wide_q ? LAST_W : LAST_N)) begin
      h_nxt = '0;
      v_nxt = (v == VLAST) ? '0 : v + 1'b1;
    end else begin
      h_nxt = h + 1'b1;
      v_nxt = v;
    end
    if (h_nxt == ACT0 || ph == ph_max) ph_nxt = 2'd0;
    else                               ph_nxt = ph + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h      <= '0;
      v      <= '0;
      ph     <= '0;
      wide_q <= wide_in;
    end else if (dot_en) begin
      h  <= h_nxt;
      v  <= v_nxt;
      ph <= ph_nxt;
      if (h_nxt == '0 && v_nxt == '0) wide_q <= wide_in;
    end
  end
endmodule

// File: rtl/lcd_slot_decode.sv
module lcd_slot_decode
  import lcd_sync_pkg::*;
#(
  parameter int H_SYNC  = 10,
  parameter int H_BACK  = 20,
  parameter int H_PIX   = 240,
  parameter int V_SYNC  = 2,
  parameter int V_BACK  = 2,
  parameter int V_LINES = 320,
  parameter int HW      = 10,
  parameter int VW      = 9
) (
  input  logic [HW-1:0] h,
  input  logic [VW-1:0] v,
  input  logic [1:0]    ph,
  input  logic          wide,
  output slot_t         slot
);
  localparam logic [HW-1:0] HS_END = HW'(H_SYNC);
  localparam logic [HW-1:0] ACT0   = HW'(H_SYNC + H_BACK);
  localparam logic [HW-1:0] END_N  = HW'(H_SYNC + H_BACK + 3*H_PIX);
  localparam logic [HW-1:0] END_W  = HW'(H_SYNC + H_BACK + H_PIX);
  localparam logic [VW-1:0] VS_END = VW'(V_SYNC);
  localparam logic [VW-1:0] VA0    = VW'(V_SYNC + V_BACK);
  localparam logic [VW-1:0] VA1    = VW'(V_SYNC + V_BACK + V_LINES);

  always_comb begin
    slot.hsync  = (h < HS_END);
    slot.vsync  = (v < VS_END);
    slot.act    = (h >= ACT0) && (h < (wide ? END_W : END_N)) && (v >= VA0) && (v < VA1);
    slot.ph     = wide ? 2'd0 : ph;
    slot.red    = slot.act && (slot.ph == 2'd0);
    slot.line0  = (h == '0);
    slot.frame0 = (h == '0) && (v == '0);
  end
endmodule

// File: rtl/lcd_pixel_serializer.sv
module lcd_pixel_serializer
  import lcd_sync_pkg::*;
#(
  parameter int CW = 6,
  parameter int PW = 3*CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dot_en,
  input  logic          wide,
  input  slot_t         slot,
  input  logic          pix_req,
  input  logic [PW-1:0] pix_data,
  output logic [PW-1:0] bus_data
);
  localparam int ZW = PW - CW;
  logic [PW-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_data <= '0;
      hold     <= '0;
    end else if (dot_en) begin
      if (!slot.act) begin
        bus_data <= '0;
      end else begin
        case (slot.ph)
          2'd0: begin
            hold     <= pix_data;
            bus_data <= wide ? pix_data : {{ZW{1'b0}}, pix_data[PW-1 -: CW]};
          end
          2'd1:    bus_data <= {{ZW{1'b0}}, hold[2*CW-1 -: CW]};
          default: bus_data <= {{ZW{1'b0}}, hold[CW-1:0]};
        endcase
      end
    end
  end

  // A pixel is taken only at the end of the tick its request covered.
  AST_RED_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    (dot_en && slot.red) |-> pix_req); // R6
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_sync_pkg::*;
#(
  parameter int H_SYNC  = 10,
  parameter int H_BACK  = 20,
  parameter int H_PIX   = 240,
  parameter int H_FRONT = 10,
  parameter int V_SYNC  = 2,
  parameter int V_BACK  = 2,
  parameter int V_LINES = 320,
  parameter int V_FRONT = 4,
  parameter int CW      = 6,
  parameter int PW      = 3*CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dot_en,
  input  logic          wide_mode,
  input  logic [PW-1:0] pix_data,
  output logic          pix_req,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          de,
  output logic [1:0]    phase,
  output logic [PW-1:0] bus_data,
  output logic          line_start,
  output logic          frame_start
);
  localparam int H_TOTAL = H_SYNC + H_BACK + 3*H_PIX + H_FRONT;
  localparam int V_TOTAL = V_SYNC + V_BACK + V_LINES + V_FRONT;
  localparam int HW      = $clog2(H_TOTAL);
  localparam int VW      = $clog2(V_TOTAL);

  logic [HW-1:0] h, h_nxt;
  logic [VW-1:0] v, v_nxt;
  logic [1:0]    ph, ph_nxt;
  logic          wide_q;
  slot_t         cur, nxt;

  lcd_hv_counter #(.H_SYNC(H_SYNC), .H_BACK(H_BACK), .H_PIX(H_PIX), .H_FRONT(H_FRONT),
                   .V_TOTAL(V_TOTAL), .HW(HW), .VW(VW)) u_cnt (
    .clk(clk), .rst(rst), .dot_en(dot_en), .wide_in(wide_mode),
    .h(h), .v(v), .ph(ph), .h_nxt(h_nxt), .v_nxt(v_nxt), .ph_nxt(ph_nxt), .wide_q(wide_q));

  lcd_slot_decode #(.H_SYNC(H_SYNC), .H_BACK(H_BACK), .H_PIX(H_PIX), .V_SYNC(V_SYNC),
                    .V_BACK(V_BACK), .V_LINES(V_LINES), .HW(HW), .VW(VW)) u_dec_cur (
    .h(h), .v(v), .ph(ph), .wide(wide_q), .slot(cur));

  lcd_slot_decode #(.H_SYNC(H_SYNC), .H_BACK(H_BACK), .H_PIX(H_PIX), .V_SYNC(V_SYNC),
                    .V_BACK(V_BACK), .V_LINES(V_LINES), .HW(HW), .VW(VW)) u_dec_nxt (
    .h(h_nxt), .v(v_nxt), .ph(ph_nxt), .wide(wide_q), .slot(nxt));

  lcd_pixel_serializer #(.CW(CW), .PW(PW)) u_ser (
    .clk(clk), .rst(rst), .dot_en(dot_en), .wide(wide_q), .slot(cur),
    .pix_req(pix_req), .pix_data(pix_data), .bus_data(bus_data));

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_n     <= 1'b1;
      vsync_n     <= 1'b1;
      de          <= 1'b0;
      phase       <= 2'd0;
      pix_req     <= 1'b0;
      line_start  <= 1'b0;
      frame_start <= 1'b0;
    end else if (dot_en) begin
      hsync_n     <= ~cur.hsync;
      vsync_n     <= ~cur.vsync;
      de          <= cur.act;
      phase       <= cur.act ? cur.ph : 2'd0;
      pix_req     <= nxt.red;
      line_start  <= cur.line0;
      frame_start <= cur.frame0;
    end
  end

  AST_FRAME_ON_LINE: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> line_start); // R2
  AST_VSYNC_WITH_HSYNC: assert property (@(posedge clk) disable iff (rst)
    $fell(vsync_n) |-> $fell(hsync_n)); // R2
  AST_BUS_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !de |-> (bus_data == '0)); // R3
  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
    (!$past(dot_en) && !$past(rst)) |-> ($stable(hsync_n) && $stable(bus_data) && $stable(pix_req))); // R8
endmodule

// File: tb/test_lcd_sync_gen.sv
module test_lcd_sync_gen;
  localparam int CLK_PERIOD = 10;
  localparam int HS = 2, HB = 3, HP = 4, HF = 2;
  localparam int VS = 2, VB = 1, VL = 3, VF = 2;
  localparam int CW = 6, PW = 18;
  localparam int AS = HS + HB;
  localparam int VT = VS + VB + VL + VF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dot_en = 1'b0;
  logic wide_mode = 1'b0;
  logic [PW-1:0] pix_data = '0;
  logic pix_req, hsync_n, vsync_n, de, line_start, frame_start;
  logic [1:0] phase;
  logic [PW-1:0] bus_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_sync_gen #(.H_SYNC(HS), .H_BACK(HB), .H_PIX(HP), .H_FRONT(HF),
                 .V_SYNC(VS), .V_BACK(VB), .V_LINES(VL), .V_FRONT(VF), .CW(CW), .PW(PW)) i_lcd_sync_gen (
    .clk(clk), .rst(rst), .dot_en(dot_en), .wide_mode(wide_mode), .pix_data(pix_data),
    .pix_req(pix_req), .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de), .phase(phase),
    .bus_data(bus_data), .line_start(line_start), .frame_start(frame_start));

  function automatic int line_len(bit m);
    return AS + HP * (m ? 1 : 3) + HF;
  endfunction
  function automatic bit is_act(int h, int v, bit m);
    return (h >= AS) && (h < AS + HP * (m ? 1 : 3)) && (v >= VS + VB) && (v < VS + VB + VL);
  endfunction
  function automatic int ph_of(int h, bit m);
    return m ? 0 : (h - AS) % 3;
  endfunction

  // Reference position model: position on display, mode of that frame, captured pixel.
  bit shown = 0;
  int mh = 0, mv = 0;
  bit mmode = 0, mode_prev = 0, last_en = 0;
  logic [PW-1:0] mcap = '0;

  always @(posedge clk) begin
    if (rst) begin
      shown = 0;
      mode_prev = wide_mode;
      last_en = 0;
    end else begin
      last_en = dot_en;
      if (dot_en) begin
        if (!shown) begin
          shown = 1; mh = 0; mv = 0; mmode = mode_prev;
        end else if (mh == line_len(mmode) - 1) begin
          mh = 0;
          mv = (mv == VT - 1) ? 0 : mv + 1;
          if (mv == 0) mmode = mode_prev;
        end else begin
          mh = mh + 1;
        end
        if (is_act(mh, mv, mmode) && ph_of(mh, mmode) == 0) mcap = pix_data;
        mode_prev = wide_mode;
      end
    end
  end

  task automatic check(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!shown) begin
        check("R9", "hsync_n", int'(hsync_n), 1);
        check("R9", "vsync_n", int'(vsync_n), 1);
        check("R9", "de", int'(de), 0);
        check("R9", "bus_data", int'(bus_data), 0);
        check("R9", "pix_req", int'(pix_req), 0);
        check("R9", "pulses", int'({line_start, frame_start, phase}), 0);
      end else begin
        automatic bit act = is_act(mh, mv, mmode);
        automatic int ph = act ? ph_of(mh, mmode) : 0;
        automatic int nh = (mh == line_len(mmode) - 1) ? 0 : mh + 1;
        automatic int nv = (nh == 0) ? ((mv == VT - 1) ? 0 : mv + 1) : mv;
        automatic bit nred = is_act(nh, nv, mmode) && ph_of(nh, mmode) == 0;
        automatic int ebus;
        automatic string tmode = (wide_mode != mmode) ? "R7" : (mmode ? "R5" : "R4");
        if (!act)       ebus = 0;
        else if (mmode) ebus = int'(mcap);
        else if (ph == 0) ebus = int'(mcap[17:12]);
        else if (ph == 1) ebus = int'(mcap[11:6]);
        else              ebus = int'(mcap[5:0]);
        check(last_en ? "R1" : "R8", "hsync_n", int'(hsync_n), int'(!(mh < HS)));
        check("R1", "line_start", int'(line_start), int'(mh == 0));
        check("R2", "vsync_n", int'(vsync_n), int'(!(mv < VS)));
        check("R2", "frame_start", int'(frame_start), int'(mh == 0 && mv == 0));
        check("R3", "de", int'(de), int'(act));
        check(act ? tmode : "R3", "bus_data", int'(bus_data), ebus);
        check(tmode, "phase", int'(phase), ph);
        check("R6", "pix_req", int'(pix_req), int'(nred));
      end
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // directed: narrow mode, continuous ticks, two frames
    dot_en = 1'b1;
    for (int i = 0; i < 400; i++) begin
      r = $urandom; pix_data = r[PW-1:0];
      if (i == 200) wide_mode = 1'b1;   // mid-frame change, must wait for boundary (R7)
      @(negedge clk);
    end
    // directed: wide mode, continuous ticks
    for (int i = 0; i < 400; i++) begin
      r = $urandom; pix_data = r[PW-1:0];
      @(negedge clk);
    end
    // random: sparse ticks, random pixels, occasional mode flips
    for (int i = 0; i < 20000; i++) begin
      r = $urandom; pix_data = r[PW-1:0];
      dot_en = ($urandom % 3) != 0;
      if (($urandom % 250) == 0) wide_mode = ~wide_mode;
      @(negedge clk);
    end
    // directed: reset in mid-frame with wide mode held, then restart (R9)
    rst = 1'b1; wide_mode = 1'b1; dot_en = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0; dot_en = 1'b0;
    repeat (2) @(negedge clk);
    dot_en = 1'b1;
    for (int i = 0; i < 500; i++) begin
      r = $urandom; pix_data = r[PW-1:0];
      if (i == 300) wide_mode = 1'b0;
      @(negedge clk);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule